// File: doc/BRIEF.md
# Interlocked dual-bus arbiter

This block arbitrates two buses at once. On the processor-side bus the CPU is the default owner, and two other agents can take the bus from it: a host bridge and a DMA engine. On the PCI-style bus the CPU and a parameterised number of external masters (five by default) compete. Each external master has one request line and one grant line. The only other inputs are a concurrency control bit, a park-policy bit and a strobe that marks the end of each CPU cycle on the processor bus.

In concurrent mode the two arbiters decide independently. In nonconcurrent mode they are coupled, so that every master owns both buses. A pending external PCI request raises a host-bridge request on the processor side. The external grant is withheld until the bridge holds the processor bus, and this applies even to peer-to-peer traffic. Nonconcurrent mode is the reset mode. A requested mode change waits until the whole unit is quiet.

Top module: `dual_bus_arbiter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the processor bus is granted to the CPU, the PCI bus is parked on the CPU, no external grant is active and the handover strobe is low.
- R2: Exactly one processor-bus grant is active in every cycle. At most one PCI grant (CPU or external) is active in every cycle.
- R3: The unit leaves reset in nonconcurrent mode, whatever the value of the mode input.
- R4: In concurrent mode, an eligible external request is granted in the cycle after it is sampled, whoever owns the processor bus.
- R5: In nonconcurrent mode, an external request raises a bridge request on the processor side. The external grant appears at the earliest one cycle after the bridge grant, and an external grant is only ever active while the bridge holds the processor bus.
- R6: The CPU gives up the processor bus only at a clock edge where the cycle-done input is high. The new grant is visible in the cycle after that edge.
- R7: When the DMA engine and the bridge both request at a handover edge, the DMA engine wins.
- R8: A grant stays asserted while its request is held. One cycle after the request drops, the processor bus returns to the CPU, and the PCI bus goes either to the next requester or to its park target.
- R9: PCI requesters are served round-robin in the index order CPU = 0, external master i = i+1. The search starts just after the most recently granted index, and the first index searched after reset is 0.
- R10: With the park-on-last bit set in concurrent mode, an idle PCI bus stays granted to its last owner. Otherwise an idle PCI bus parks on the CPU. Nonconcurrent mode always forces parking on the CPU.
- R11: The handover strobe is high for exactly the first cycle of each new processor-bus grant, including a return to the CPU.
- R12: A change on the mode input takes effect only at an edge where no request line is active and the CPU holds the processor bus. Until then the old mode keeps governing the grants.
- R13: In nonconcurrent mode, the CPU's PCI grant (parked or requested) is active only while the CPU also holds the processor bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| conc_mode_i | input | 1 | 1 requests concurrent mode, 0 requests nonconcurrent mode |
| park_last_i | input | 1 | 1 requests parking the PCI bus on its last owner |
| cpu_cyc_done_i | input | 1 | High in the last clock of a CPU processor-bus cycle |
| dma_req_i | input | 1 | DMA engine requests the processor bus |
| bridge_req_i | input | 1 | Host bridge requests the processor bus for its own traffic |
| cpu_pci_req_i | input | 1 | CPU requests the PCI bus |
| ext_req_i | input | NUM_EXT | Request lines of the external PCI masters |
| pbus_gnt_cpu_o | output | 1 | Processor bus granted to the CPU |
| pbus_gnt_bridge_o | output | 1 | Processor bus granted to the host bridge |
| pbus_gnt_dma_o | output | 1 | Processor bus granted to the DMA engine |
| pbus_xfer_o | output | 1 | First cycle of a new processor-bus grant |
| pci_gnt_cpu_o | output | 1 | PCI bus granted to (or parked on) the CPU |
| ext_gnt_o | output | NUM_EXT | Grant lines of the external PCI masters |

## Verification
The properties assume that every agent holds its request until it has been granted and has finished, and that the cycle-done strobe marks real CPU cycle ends. Under those assumptions grant exclusivity and the nonconcurrent coupling can be stated as plain implications. The directed stimulus changes inputs only on falling edges and drops a request only while it is granted or has never been granted. It also flips the mode and park inputs while traffic is still pending, so that the deferral path is exercised.

// File: rtl/dba_pkg.sv
package dba_pkg;
  // Processor-side bus owner encoding
  typedef enum logic [1:0] {
    PO_CPU    = 2'd0,
    PO_BRIDGE = 2'd1,
    PO_DMA    = 2'd2
  } pbus_own_e;
endpackage

// File: rtl/dba_mode_ctl.sv
// Holds the effective arbitration mode; a new mode is latched only when idle.
module dba_mode_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_req_i,
  input  logic idle_i,
  output logic conc_q_o,
  output logic conc_nxt_o
);
  logic conc_q;
  logic upd_en;

  assign upd_en     = idle_i & (mode_req_i != conc_q);
  assign conc_nxt_o = upd_en ? mode_req_i : conc_q;
  assign conc_q_o   = conc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conc_q <= 1'b0;
    end else if (upd_en) begin
      conc_q <= mode_req_i;
    end
  end
endmodule

// File: rtl/dba_pbus_arb.sv
// Processor-side arbiter: CPU default owner, DMA ahead of the bridge.
module dba_pbus_arb import dba_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpu_done_i,
  input  logic       dma_req_i,
  input  logic       br_req_i,
  output logic [2:0] gnt_o,          // {dma, bridge, cpu}
  output logic       own_cpu_nxt_o,
  output logic       xfer_o
);
  pbus_own_e own_q, own_d;
  logic      xfer_q, xfer_d;
  logic      upd_en;

  always_comb begin
    own_d = own_q;
    case (own_q)
      PO_CPU: begin
        if (cpu_done_i) begin
          if (dma_req_i)     own_d = PO_DMA;
          else if (br_req_i) own_d = PO_BRIDGE;
        end
      end
      PO_BRIDGE: if (!br_req_i)  own_d = PO_CPU;
      PO_DMA:    if (!dma_req_i) own_d = PO_CPU;
      default:   own_d = PO_CPU;
    endcase
  end

  assign xfer_d = (own_d != own_q);
  assign upd_en = xfer_d | xfer_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q  <= PO_CPU;
      xfer_q <= 1'b0;
    end else if (upd_en) begin
      own_q  <= own_d;
      xfer_q <= xfer_d;
    end
  end

  assign gnt_o         = {own_q == PO_DMA, own_q == PO_BRIDGE, own_q == PO_CPU};
  assign own_cpu_nxt_o = (own_d == PO_CPU);
  assign xfer_o        = xfer_q;
endmodule

// File: rtl/dba_rr_pick.sv
// Rotating search: first set request strictly after last_i, wrapping.
module dba_rr_pick #(
  parameter int N  = 6,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  input  logic [IW-1:0] last_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  logic [IW-1:0] pos;

  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    pos     = '0;
    // scan from farthest to nearest so the nearest hit wins
    for (int k = N; k >= 1; k--) begin
      pos = IW'((int'(last_i) + k) % N);
      if (req_i[pos]) begin
        found_o = 1'b1;
        idx_o   = pos;
      end
    end
  end
endmodule

// File: rtl/dba_pci_arb.sv
// PCI-side arbiter: index 0 is the CPU, index i+1 is external master i.
module dba_pci_arb #(
  parameter int NUM_EXT = 5,
  localparam int NREQ   = NUM_EXT + 1,
  localparam int IW     = $clog2(NREQ)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_req_i,
  input  logic [NUM_EXT-1:0] ext_req_i,
  input  logic               cpu_ok_i,
  input  logic               ext_ok_i,
  input  logic               park_last_i,
  output logic [NREQ-1:0]    gnt_o
);
  logic [NREQ-1:0] own_q, own_d, mreq, win_vec;
  logic [IW-1:0]   last_q, last_d, win_idx;
  logic            found, hold, upd_en;

  assign mreq = {ext_req_i & {NUM_EXT{ext_ok_i}}, cpu_req_i & cpu_ok_i};
  assign hold = |(own_q & mreq);

  dba_rr_pick #(.N(NREQ), .IW(IW)) u_pick (
    .req_i   (mreq),
    .last_i  (last_q),
    .found_o (found),
    .idx_o   (win_idx)
  );

  for (genvar g = 0; g < NREQ; g++) begin : g_dec
    assign win_vec[g] = (win_idx == IW'(g));
  end

  always_comb begin
    own_d  = own_q;
    last_d = last_q;
    if (!hold) begin
      if (found) begin
        own_d  = win_vec;
        last_d = win_idx;
      end else if (!park_last_i) begin
        own_d    = '0;
        own_d[0] = cpu_ok_i;
      end
    end
  end

  assign upd_en = (own_d != own_q) | (last_d != last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q  <= NREQ'(1);
      last_q <= IW'(NUM_EXT);
    end else if (upd_en) begin
      own_q  <= own_d;
      last_q <= last_d;
    end
  end

  assign gnt_o = own_q;
endmodule

// File: rtl/dual_bus_arbiter.sv
// Two arbiters, optionally interlocked through the host bridge.
module dual_bus_arbiter #(
  parameter int NUM_EXT = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               conc_mode_i,
  input  logic               park_last_i,
  input  logic               cpu_cyc_done_i,
  input  logic               dma_req_i,
  input  logic               bridge_req_i,
  input  logic               cpu_pci_req_i,
  input  logic [NUM_EXT-1:0] ext_req_i,
  output logic               pbus_gnt_cpu_o,
  output logic               pbus_gnt_bridge_o,
  output logic               pbus_gnt_dma_o,
  output logic               pbus_xfer_o,
  output logic               pci_gnt_cpu_o,
  output logic [NUM_EXT-1:0] ext_gnt_o
);
  localparam int NREQ = NUM_EXT + 1;

  logic            eff_conc_q, eff_conc_nxt;
  logic            idle, br_req_int, own_cpu_nxt;
  logic            cpu_ok, ext_ok, park_last_eff;
  logic [2:0]      pgnt;
  logic [NREQ-1:0] pci_gnt;

  assign idle = pgnt[0] & ~dma_req_i & ~bridge_req_i & ~cpu_pci_req_i & ~(|ext_req_i);

  dba_mode_ctl u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_req_i (conc_mode_i),
    .idle_i     (idle),
    .conc_q_o   (eff_conc_q),
    .conc_nxt_o (eff_conc_nxt)
  );

  // interlock: external PCI traffic must come through the bridge
  assign br_req_int = bridge_req_i | (~eff_conc_q & (|ext_req_i));

  dba_pbus_arb u_pbus (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_done_i    (cpu_cyc_done_i),
    .dma_req_i     (dma_req_i),
    .br_req_i      (br_req_int),
    .gnt_o         (pgnt),
    .own_cpu_nxt_o (own_cpu_nxt),
    .xfer_o        (pbus_xfer_o)
  );

  assign cpu_ok        = eff_conc_nxt | own_cpu_nxt;
  assign ext_ok        = eff_conc_nxt | pgnt[1];
  assign park_last_eff = park_last_i & eff_conc_nxt;

  dba_pci_arb #(.NUM_EXT(NUM_EXT)) u_pci (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_req_i   (cpu_pci_req_i),
    .ext_req_i   (ext_req_i),
    .cpu_ok_i    (cpu_ok),
    .ext_ok_i    (ext_ok),
    .park_last_i (park_last_eff),
    .gnt_o       (pci_gnt)
  );

  assign pbus_gnt_cpu_o    = pgnt[0];
  assign pbus_gnt_bridge_o = pgnt[1];
  assign pbus_gnt_dma_o    = pgnt[2];
  assign pci_gnt_cpu_o     = pci_gnt[0];
  assign ext_gnt_o         = pci_gnt[NREQ-1:1];
endmodule

// File: rtl/dual_bus_arbiter_chk.sv
module dual_bus_arbiter_chk #(
  parameter int NUM_EXT = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               eff_conc,
  input logic               park_last,
  input logic               cpu_done,
  input logic               dma_req,
  input logic               bridge_req,
  input logic               cpu_pci_req,
  input logic [NUM_EXT-1:0] ext_req,
  input logic               g_cpu,
  input logic               g_br,
  input logic               g_dma,
  input logic               xfer,
  input logic               pci_cpu,
  input logic [NUM_EXT-1:0] ext_gnt
);
  // R2
  pbus_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({g_dma, g_br, g_cpu}));
  // R2
  pci_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ext_gnt, pci_cpu}));
  // R5
  nc_ext_bridge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!eff_conc && (|ext_gnt)) |-> g_br);
  // R6
  cpu_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(g_cpu) |-> $past(cpu_done));
  // R7
  dma_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (g_cpu && cpu_done && dma_req) |=> g_dma);
  // R8
  dma_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (g_dma && dma_req) |=> g_dma);
  // R8
  dma_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (g_dma && !dma_req) |=> g_cpu);
  // R11
  xfer_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({g_dma, g_br, g_cpu}) |-> xfer);
  // R11
  xfer_only_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |-> !$stable({g_dma, g_br, g_cpu}));
  // R12
  mode_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(eff_conc) |->
      $past(g_cpu && !dma_req && !bridge_req && !cpu_pci_req && (ext_req == '0)));
  // R13
  nc_cpu_pci_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!eff_conc && pci_cpu) |-> g_cpu);
  // R10
  park_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!park_last && !cpu_pci_req && (ext_req == '0)) |=> (ext_gnt == '0));
endmodule

bind dual_bus_arbiter dual_bus_arbiter_chk #(.NUM_EXT(NUM_EXT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .eff_conc    (eff_conc_q),
  .park_last   (park_last_i),
  .cpu_done    (cpu_cyc_done_i),
  .dma_req     (dma_req_i),
  .bridge_req  (bridge_req_i),
  .cpu_pci_req (cpu_pci_req_i),
  .ext_req     (ext_req_i),
  .g_cpu       (pbus_gnt_cpu_o),
  .g_br        (pbus_gnt_bridge_o),
  .g_dma       (pbus_gnt_dma_o),
  .xfer        (pbus_xfer_o),
  .pci_cpu     (pci_gnt_cpu_o),
  .ext_gnt     (ext_gnt_o)
);

// File: tb/dual_bus_arbiter_tb.sv
`timescale 1ns/1ps
module dual_bus_arbiter_tb;
  localparam int NE = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          conc_mode, park_last, cpu_done, dma_req, bridge_req, cpu_pci_req;
  logic [NE-1:0] ext_req;
  logic          g_cpu, g_br, g_dma, xfer, pci_cpu;
  logic [NE-1:0] ext_gnt;

  int vec = 0;
  int err = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dual_bus_arbiter #(.NUM_EXT(NE)) u_dut (
    .clk               (clk),
    .rst_n             (rst_n),
    .conc_mode_i       (conc_mode),
    .park_last_i       (park_last),
    .cpu_cyc_done_i    (cpu_done),
    .dma_req_i         (dma_req),
    .bridge_req_i      (bridge_req),
    .cpu_pci_req_i     (cpu_pci_req),
    .ext_req_i         (ext_req),
    .pbus_gnt_cpu_o    (g_cpu),
    .pbus_gnt_bridge_o (g_br),
    .pbus_gnt_dma_o    (g_dma),
    .pbus_xfer_o       (xfer),
    .pci_gnt_cpu_o     (pci_cpu),
    .ext_gnt_o         (ext_gnt)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one clock; inputs were driven at a falling edge, sample at the next one
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    chk("R2 processor grant one-hot", 32'($countones({g_dma, g_br, g_cpu})), 32'd1);
    chk("R2 PCI grant at most one", 32'($countones({ext_gnt, pci_cpu}) <= 1), 32'd1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; conc_mode = 1'b1; park_last = 1'b0; cpu_done = 1'b0;
    dma_req = 1'b0; bridge_req = 1'b0; cpu_pci_req = 1'b0; ext_req = '0;
    repeat (3) @(negedge clk);
    chk("R1 pbus grant", 32'({g_dma, g_br, g_cpu}), 32'b001);
    chk("R1 pci cpu park", 32'(pci_cpu), 32'd1);
    chk("R1 ext grants", 32'(ext_gnt), 32'd0);
    chk("R1 strobe", 32'(xfer), 32'd0);
  endtask

  // released with mode input high: unit must still behave nonconcurrent
  task automatic t_reset_mode_interlock();
    rst_n = 1'b1; ext_req = 5'b00001;
    step(); step();
    chk("R3 no ext grant after reset", 32'(ext_gnt), 32'd0);
    chk("R6 cpu keeps pbus without done", 32'(g_cpu), 32'd1);
    cpu_done = 1'b1;
    step();
    chk("R5 bridge takes pbus", 32'({g_dma, g_br, g_cpu}), 32'b010);
    chk("R11 strobe on handover", 32'(xfer), 32'd1);
    chk("R5 ext not yet granted", 32'(ext_gnt), 32'd0);
    chk("R13 cpu pci grant dropped", 32'(pci_cpu), 32'd0);
    cpu_done = 1'b0;
    step();
    chk("R5 ext0 granted after bridge", 32'(ext_gnt), 32'b00001);
    chk("R11 strobe one cycle", 32'(xfer), 32'd0);
    ext_req = '0;
    step();
    chk("R8 pbus back to cpu", 32'({g_dma, g_br, g_cpu}), 32'b001);
    chk("R8 pci parks on cpu", 32'({ext_gnt, pci_cpu}), 32'b000001);
    step();  // idle edge: concurrent mode is latched
  endtask

  task automatic t_concurrent();
    ext_req = 5'b00100;
    step();
    chk("R4 ext2 granted without bridge", 32'(ext_gnt), 32'b00100);
    chk("R4 cpu keeps pbus", 32'({g_dma, g_br, g_cpu}), 32'b001);
    ext_req = '0;
    step();
    chk("R10 idle parks on cpu", 32'({ext_gnt, pci_cpu}), 32'b000001);
  endtask

  task automatic t_round_robin();
    ext_req = 5'b10110;
    step();
    chk("R9 after ext2 next is ext4", 32'(ext_gnt), 32'b10000);
    ext_req = 5'b00110;
    step();
    chk("R9 wrap to ext1", 32'(ext_gnt), 32'b00010);
    ext_req = 5'b00100;
    step();
    chk("R9 then ext2", 32'(ext_gnt), 32'b00100);
    ext_req = '0;
    step();
  endtask

  task automatic t_park_and_mode();
    park_last = 1'b1; ext_req = 5'b01000;
    step();
    chk("R9 ext3 granted", 32'(ext_gnt), 32'b01000);
    ext_req = '0;
    step();
    chk("R10 parked on last owner", 32'(ext_gnt), 32'b01000);
    conc_mode = 1'b0; ext_req = 5'b00010;
    step();
    chk("R12 still concurrent ext1", 32'(ext_gnt), 32'b00010);
    step();
    chk("R8 ext1 held", 32'(ext_gnt), 32'b00010);
    ext_req = 5'b01000;
    step();
    chk("R12 old mode while busy", 32'(ext_gnt), 32'b01000);
    ext_req = '0;
    step();
    chk("R10 forced cpu park on switch", 32'({ext_gnt, pci_cpu}), 32'b000001);
    ext_req = 5'b00001;
    step(); step();
    chk("R12 nonconcurrent now active", 32'(ext_gnt), 32'd0);
    ext_req = '0; park_last = 1'b0;
    step();
  endtask

  task automatic t_dma();
    dma_req = 1'b1;
    step(); step();
    chk("R6 dma waits for cycle end", 32'({g_dma, g_br, g_cpu}), 32'b001);
    cpu_done = 1'b1;
    step();
    chk("R6 dma granted after done", 32'({g_dma, g_br, g_cpu}), 32'b100);
    chk("R11 strobe on dma grant", 32'(xfer), 32'd1);
    chk("R13 no cpu pci grant", 32'(pci_cpu), 32'd0);
    cpu_done = 1'b0;
    step();
    chk("R8 dma held", 32'(g_dma), 32'd1);
    chk("R11 strobe low while held", 32'(xfer), 32'd0);
    dma_req = 1'b0;
    step();
    chk("R8 return to cpu", 32'({g_dma, g_br, g_cpu}), 32'b001);
    chk("R11 strobe on return", 32'(xfer), 32'd1);
    chk("R13 cpu pci park restored", 32'(pci_cpu), 32'd1);
  endtask

  task automatic t_priority();
    dma_req = 1'b1; bridge_req = 1'b1; cpu_done = 1'b1;
    step();
    chk("R7 dma beats bridge", 32'({g_dma, g_br, g_cpu}), 32'b100);
    cpu_done = 1'b0; dma_req = 1'b0;
    step();
    chk("R8 default owner before bridge", 32'({g_dma, g_br, g_cpu}), 32'b001);
    cpu_done = 1'b1;
    step();
    chk("R6 bridge granted", 32'({g_dma, g_br, g_cpu}), 32'b010);
    cpu_done = 1'b0; bridge_req = 1'b0;
    step();
    chk("R8 bridge released", 32'({g_dma, g_br, g_cpu}), 32'b001);
  endtask

  initial begin
    t_reset();
    t_reset_mode_interlock();
    t_concurrent();
    t_round_robin();
    t_park_and_mode();
    t_dma();
    t_priority();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      err++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vec, err);
      $finish;
    end
  end
endmodule